// File: doc/BRIEF.md
# Dual-Slope Buffered PWM Generator

This block makes a single pulse-width-modulated output from an 8-bit counter. Each cycle with the `tick` strobe high moves the counter one step. The counter runs in one of two waveform modes. In single-slope mode it climbs from zero to the top value and wraps back to zero. In dual-slope mode it climbs to the top value and then descends to zero. A compare value sets the duty cycle, and a polarity input chooses non-inverting or inverting output.

The compare value written by the host goes into a holding register. The counter copies it into the active register each time it leaves the top value, so a period never uses two compare values. The polarity input and the output-enable input take effect without buffering. With the output enable low, the pin shows a static level supplied from outside. With it high, the pin shows the internal waveform state at once.

Single-slope mode keeps its known limits: a compare value of zero still gives a one-count pulse, and only the largest compare value gives a constant level. Dual-slope mode gives a clean 0% and a clean 100%, but its period is twice as long.

Top module: `pwm_gen_dm`

## Requirements
- R1: With `rst_n` low at a clock edge, the counter goes to 0, the internal waveform goes low and the direction goes to counting up. After reset, `count_o` reads 0 and `pwm_out` reads 0 while `out_en` is 1.
- R2: The counter and waveform change only in cycles where `tick` is 1. With `tick` at 0, `count_o` holds its value.
- R3: With `mode` at 0 (single-slope), the counter goes 0,1,...,255 and then back to 0, so a period lasts 256 ticks.
- R4: In single-slope mode with `invert` at 0, the output is high for k+1 of every 256 ticks, where k is the active compare value. k=0 gives a one-tick pulse and k=255 gives a constant high.
- R5: In single-slope mode with `invert` at 1, the output is high for 255-k of every 256 ticks. k=255 gives a constant low, and no compare value gives a constant high.
- R6: With `mode` at 1 (dual-slope), the counter climbs to 255 and then steps to 254 and down to 0 before climbing again, so a period lasts 510 ticks.
- R7: In dual-slope mode with `invert` at 0, the output is high for 2k of every 510 ticks. k=0 gives a constant low and k=255 gives a constant high.
- R8: In dual-slope mode with `invert` at 1, the output is high for 510-2k of every 510 ticks.
- R9: A `cmp_wr` pulse stores `cmp_data` in the holding register only. The active compare value changes only on a tick taken while the counter is at 255, so a write made mid-period leaves the rest of that period unchanged.
- R10: While `out_en` is 0, `pwm_out` equals `port_level` in the same cycle. When `out_en` returns to 1, `pwm_out` shows the held waveform state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one step per high cycle |
| mode | input | 1 | 0 single-slope, 1 dual-slope |
| invert | input | 1 | 0 non-inverting, 1 inverting |
| out_en | input | 1 | 1 drives the waveform, 0 drives `port_level` |
| port_level | input | 1 | Static level shown while the waveform is disconnected |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_data | input | 8 | Compare value to store |
| pwm_out | output | 1 | Output pin level |
| count_o | output | 8 | Current counter value |

## Verification
The assertions assume that `mode` changes only around a reset. A mode switch while the counter runs would leave the direction flag pointing the wrong way at the bottom, so the checks on the counter's turning points would no longer describe one mode. The bench therefore pulses `rst_n` each time it changes `mode`. It only changes `invert` and the compare value while the counter runs. Each duty measurement waits for two passes through the top value after a write, so that both the active value and the waveform state have settled before the window opens.

// File: rtl/pwm_gen_pkg.sv
// Package for the PWM generator: waveform mode encoding and the default
// counter width. Assumes nothing beyond two-state mode selection.
package pwm_gen_pkg;

    // Waveform mode as carried on the 1-bit mode pin
    typedef enum logic {
        SLOPE_SINGLE = 1'b0,
        SLOPE_DUAL   = 1'b1
    } slope_e;

    localparam int unsigned DEF_CNT_W = 8;

endpackage

// File: rtl/pwm_gen_counter.sv
// Up or up/down counter for the PWM generator.
// Single-slope: 0..TOP then wrap to 0. Dual-slope: 0..TOP..0 with the
// direction flag flipped on arrival at TOP (down) and at 0 (up).
// Assumes the mode only changes around a reset.
module pwm_gen_counter
    import pwm_gen_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  slope_e           slope,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             dir_up_d,
    output logic             at_top
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic dir_up_q;

    // Next count and next direction for the selected slope
    always_comb begin
        at_top = (cnt_q == TOP);
        if (slope == SLOPE_DUAL) begin
            cnt_d = dir_up_q ? (cnt_q + ONE) : (cnt_q - ONE);
            if (cnt_d == TOP)
                dir_up_d = 1'b0;
            else if (cnt_d == '0)
                dir_up_d = 1'b1;
            else
                dir_up_d = dir_up_q;
        end else begin
            cnt_d    = at_top ? '0 : (cnt_q + ONE);
            dir_up_d = 1'b1;
        end
    end

    // Count and direction registers, advanced on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
        end else if (tick) begin
            cnt_q    <= cnt_d;
            dir_up_q <= dir_up_d;
        end
    end

endmodule

// File: rtl/pwm_gen_cmp_buf.sv
// Double-buffered compare value. Writes land in the holding register.
// The active register copies it on a tick taken at TOP.
// Assumes at_top comes from the same counter that drives the waveform.
module pwm_gen_cmp_buf #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             at_top,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cmp_act
);

    logic [CNT_W-1:0] cmp_hold;

    // Holding register written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_hold <= '0;
        else if (wr)
            cmp_hold <= wr_data;
    end

    // Active register reloaded when the counter leaves TOP
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_act <= '0;
        else if (tick && at_top)
            cmp_act <= cmp_hold;
    end

endmodule

// File: rtl/pwm_gen_wave.sv
// Waveform state register. Single-slope: the active level is applied on
// arrival at 0, and the opposite level on leaving the compare count
// (the arrival at 0 wins). Dual-slope: on arrival at the compare count
// the opposite level is applied when climbing and the active level when
// descending. Inverting polarity swaps both levels and is not buffered.
module pwm_gen_wave
    import pwm_gen_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  slope_e           slope,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             dir_up_d,
    input  logic [CNT_W-1:0] cmp_act,
    output logic             wave_q
);

    logic lvl_on;
    logic lvl_off;
    logic wave_d;

    // Next waveform state from the compare and boundary events
    always_comb begin
        lvl_on  = ~invert;
        lvl_off = invert;
        wave_d  = wave_q;
        if (slope == SLOPE_DUAL) begin
            if (cnt_d == cmp_act)
                wave_d = dir_up_d ? lvl_off : lvl_on;
        end else begin
            if (cnt_d == '0)
                wave_d = lvl_on;
            else if (cnt_q == cmp_act)
                wave_d = lvl_off;
        end
    end

    // Waveform register, updated on tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (tick)
            wave_q <= wave_d;
    end

endmodule

// File: rtl/pwm_gen_dm.sv
// Top of the dual-mode buffered PWM generator: counter, compare buffer
// and waveform register, plus the unbuffered pin-source select.
// Assumes mode changes only around a reset.
module pwm_gen_dm
    import pwm_gen_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode,
    input  logic             invert,
    input  logic             out_en,
    input  logic             port_level,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_o
);

    slope_e           slope;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             dir_up_d;
    logic             at_top;
    logic [CNT_W-1:0] cmp_act;
    logic             wave_q;

    assign slope = slope_e'(mode);

    pwm_gen_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .slope    (slope),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .dir_up_d (dir_up_d),
        .at_top   (at_top)
    );

    pwm_gen_cmp_buf #(.CNT_W(CNT_W)) cmp_buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .at_top  (at_top),
        .wr      (cmp_wr),
        .wr_data (cmp_data),
        .cmp_act (cmp_act)
    );

    pwm_gen_wave #(.CNT_W(CNT_W)) wave_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .slope    (slope),
        .invert   (invert),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .dir_up_d (dir_up_d),
        .cmp_act  (cmp_act),
        .wave_q   (wave_q)
    );

    // Pin source: waveform when enabled, static level otherwise
    assign pwm_out = out_en ? wave_q : port_level;
    assign count_o = cnt_q;

endmodule

// File: rtl/pwm_gen_dm_chk.sv
// Checker for pwm_gen_dm, attached by bind. Assumes mode is steady
// between resets.
module pwm_gen_dm_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             mode,
    input logic             out_en,
    input logic             port_level,
    input logic             pwm_out,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] cmp_act
);

    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

    a_r3_single_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mode && count_o == TOP) |=> (count_o == '0));

    a_r6_dual_turns_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode && count_o == TOP) |=> (count_o == TOP - 1'b1));

    a_r9_cmp_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && count_o == TOP) |=> $stable(cmp_act));

    a_r10_static_level: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pwm_out == port_level));

endmodule

bind pwm_gen_dm pwm_gen_dm_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode),
    .out_en     (out_en),
    .port_level (port_level),
    .pwm_out    (pwm_out),
    .count_o    (count_o),
    .cmp_act    (cmp_act)
);

// File: tb/pwm_gen_dm_tb_top.sv
// Scoreboard bench: the driver queues expected high counts per period,
// the monitor measures one full period from count 0 and compares.
module pwm_gen_dm_tb_top;

    typedef struct {
        int    exp_hi;
        int    len;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode = 1'b0;
    logic       invert = 1'b0;
    logic       out_en = 1'b1;
    logic       port_level = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_data = 8'd0;
    logic       pwm_out;
    logic [7:0] count_o;

    int    n_checks = 0;
    int    n_errors = 0;
    item_t sb_q[$];
    logic  mon_busy = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    pwm_gen_dm dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode       (mode),
        .invert     (invert),
        .out_en     (out_en),
        .port_level (port_level),
        .cmp_wr     (cmp_wr),
        .cmp_data   (cmp_data),
        .pwm_out    (pwm_out),
        .count_o    (count_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cmp(input int val);
        @(negedge clk);
        cmp_data = val[7:0];
        cmp_wr   = 1'b1;
        @(negedge clk);
        cmp_wr   = 1'b0;
    endtask

    // Returns at a negedge where count_o is 255
    task automatic wait_top();
        @(negedge clk);
        while (count_o != 8'hFF) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    // Settle a compare value, then queue one period measurement
    task automatic run_duty(input int k, input int exp_hi, input int len, input string tag);
        write_cmp(k);
        wait_top();
        wait_top();
        sb_q.push_back('{exp_hi, len, tag});
        wait_idle();
    endtask

    // Monitor: one window of len ticks starting at count 0
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0 && count_o == 8'd0) begin
                item_t it;
                int    hi;
                it       = sb_q.pop_front();
                mon_busy = 1'b1;
                hi       = pwm_out ? 1 : 0;
                for (int i = 1; i < it.len; i++) begin
                    @(negedge clk);
                    if (pwm_out) hi++;
                end
                check(hi == it.exp_hi, it.tag, hi, it.exp_hi);
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : driver
        int v;
        int kv[$];
        for (int k = 0; k < 256; k += 15) kv.push_back(k);
        kv.push_back(1);
        kv.push_back(254);

        // R1 reset state
        tick = 1'b1;
        do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(count_o == 8'd0, "R1 count after reset", count_o, 0);
        check(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);
        rst_n = 1'b1;

        // R2 hold without tick
        repeat (7) @(negedge clk);
        v = count_o;
        tick = 1'b0;
        repeat (5) @(negedge clk);
        check(count_o == v[7:0], "R2 count held", count_o, v);
        tick = 1'b1;
        @(negedge clk);
        check(count_o == v[7:0] + 8'd1, "R2 count resumes", count_o, v + 1);

        // R3 single-slope wrap
        wait_top();
        @(negedge clk);
        check(count_o == 8'd0, "R3 wrap to zero", count_o, 0);

        // R4 single-slope non-inverting
        invert = 1'b0;
        foreach (kv[i]) run_duty(kv[i], kv[i] + 1, 256, $sformatf("R4 k=%0d", kv[i]));
        // R5 single-slope inverting
        invert = 1'b1;
        foreach (kv[i]) run_duty(kv[i], 255 - kv[i], 256, $sformatf("R5 k=%0d", kv[i]));

        // R9 mid-period write leaves the running period alone
        invert = 1'b0;
        write_cmp(100);
        wait_top();
        wait_top();
        sb_q.push_back('{101, 256, "R9 old value kept"});
        @(negedge clk);
        while (count_o != 8'd10) @(negedge clk);
        cmp_data = 8'd200;
        cmp_wr   = 1'b1;
        @(negedge clk);
        cmp_wr   = 1'b0;
        wait_idle();
        wait_top();
        wait_top();
        sb_q.push_back('{201, 256, "R9 new value used"});
        wait_idle();

        // R10 static level and immediate return
        write_cmp(255);
        wait_top();
        wait_top();
        @(negedge clk);
        out_en = 1'b0;
        port_level = 1'b0;
        #1 check(pwm_out == 1'b0, "R10 static low", pwm_out, 0);
        @(negedge clk);
        port_level = 1'b1;
        #1 check(pwm_out == 1'b1, "R10 static high", pwm_out, 1);
        @(negedge clk);
        port_level = 1'b0;
        out_en = 1'b1;
        #1 check(pwm_out == 1'b1, "R10 waveform back", pwm_out, 1);

        // Dual-slope, after reset
        mode = 1'b1;
        invert = 1'b0;
        do_reset();
        wait_top();
        @(negedge clk);
        check(count_o == 8'd254, "R6 turn after top", count_o, 254);
        @(negedge clk);
        while (count_o != 8'd0) @(negedge clk);
        v = 0;
        @(negedge clk);
        while (count_o != 8'd0) begin
            v++;
            @(negedge clk);
        end
        check(v + 1 == 510, "R6 period length", v + 1, 510);

        // R7 dual-slope non-inverting
        foreach (kv[i]) run_duty(kv[i], 2 * kv[i], 510, $sformatf("R7 k=%0d", kv[i]));
        // R8 dual-slope inverting
        invert = 1'b1;
        foreach (kv[i]) run_duty(kv[i], 510 - 2 * kv[i], 510, $sformatf("R8 k=%0d", kv[i]));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule